// File: doc/BRIEF.md
# K2 Byte Line Alarm Integrator

This block watches the K2 byte of the line overhead, one sample per received frame, and turns two raw per-frame line conditions into filtered alarm levels. A frame carries the line alarm-indication condition when the low three bits of K2 read 111. It carries the far-end receive-failure condition when those bits read 110.

Each alarm integrates its condition over consecutive frames. While an alarm is clear, it counts the frames in a row that carry its condition and asserts once the count meets a programmable set threshold. While an alarm is set, it counts the frames in a row that lack its condition and drops once that count meets a separate programmable clear threshold. Any frame that breaks the run restarts the running count. All state moves only on the frame strobe. The frame aligner upstream supplies that strobe together with the extracted K2 byte.

Top module: `k2_line_alarm`

## Requirements
- R1: With bit 0 as the LSB, a frame carries the AIS condition when `k2_byte[2:0]` is 3'b111, and the far-end-fail condition when it is 3'b110. No other value carries either condition, and bits 7..3 are ignored.
- R2: A clear alarm goes high on the clock edge that samples the strobe of the Nth consecutive frame carrying its condition, where N is that alarm's set threshold.
- R3: While an alarm is clear, a frame without its condition restarts the consecutive count from zero.
- R4: A set alarm goes low on the clock edge that samples the strobe of the Mth consecutive frame lacking its condition, where M is that alarm's clear threshold.
- R5: A set alarm stays high while its condition keeps arriving. A condition frame during a clearing run restarts the clear count from zero.
- R6: A threshold value of 0 behaves exactly as a threshold of 1.
- R7: On clock edges without a frame strobe, neither the alarms nor their counts change.
- R8: While `rst_n` is low, both alarms are low and both counts are zero.
- R9: The two alarms run independently, each with its own pair of thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, covers hardware and software reset |
| frame_stb | input | 1 | One-cycle pulse marking a valid K2 sample |
| k2_byte | input | 8 | Received K2 byte |
| ais_set_thr | input | 4 | Consecutive AIS frames needed to assert (0 acts as 1) |
| ais_clr_thr | input | 4 | Consecutive non-AIS frames needed to clear (0 acts as 1) |
| fef_set_thr | input | 4 | Consecutive far-end-fail frames needed to assert (0 acts as 1) |
| fef_clr_thr | input | 4 | Consecutive non-far-end-fail frames needed to clear (0 acts as 1) |
| line_ais | output | 1 | Filtered line AIS alarm |
| far_end_fail | output | 1 | Filtered far-end receive-failure alarm |

## Verification
The bench targets the following corner cases and the faults each one exposes:

- **Off-by-one threshold.** A design that compares before incrementing would assert one frame late.
- **Broken run.** A design that fails to restart the count on a broken run would assert after non-consecutive frames.
- **AIS pattern 111 fed to the far-end-fail alarm.** A design with a loose pattern match would let 111 trigger far-end fail as well.
- **Zero thresholds.** A design without the zero-as-one rule would never assert, or would wrap the count through all 16 values.
- **Idle cycles between strobes.** A design that counts idle cycles would move early.

Random traffic with changing thresholds is compared frame by frame against a reference model in the bench. A mid-alarm reset is also checked.

// File: rtl/k2_line_alarm.sv
module k2_line_alarm #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [7:0]       k2_byte,
  input  logic [CNT_W-1:0] ais_set_thr,
  input  logic [CNT_W-1:0] ais_clr_thr,
  input  logic [CNT_W-1:0] fef_set_thr,
  input  logic [CNT_W-1:0] fef_clr_thr,
  output logic             line_ais,
  output logic             far_end_fail
);

  localparam int NA = 2;

  logic [NA-1:0]    cond;
  logic [NA-1:0]    alarm;
  logic [CNT_W-1:0] set_thr [NA];
  logic [CNT_W-1:0] clr_thr [NA];

  assign cond[0] = (k2_byte[2:0] == 3'b111);
  assign cond[1] = (k2_byte[2:0] == 3'b110);

  assign set_thr[0] = ais_set_thr;
  assign clr_thr[0] = ais_clr_thr;
  assign set_thr[1] = fef_set_thr;
  assign clr_thr[1] = fef_clr_thr;

  assign line_ais     = alarm[0];
  assign far_end_fail = alarm[1];

  for (genvar i = 0; i < NA; i++) begin : g_alarm
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             hit;
    logic [CNT_W:0]   nxt;

    assign hit = alarm[i] ? ~cond[i] : cond[i];
    assign lim = alarm[i] ? clr_thr[i] : set_thr[i];
    assign nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt      <= '0;
        alarm[i] <= 1'b0;
      end else if (frame_stb) begin
        if (!hit) begin
          cnt <= '0;
        end else if (nxt >= {1'b0, lim}) begin
          cnt      <= '0;
          alarm[i] <= ~alarm[i];
        end else begin
          cnt <= nxt[CNT_W-1:0];
        end
      end
    end
  end

endmodule

module k2_line_alarm_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic [7:0]       k2_byte,
  input logic [CNT_W-1:0] ais_set_thr,
  input logic [CNT_W-1:0] ais_clr_thr,
  input logic [CNT_W-1:0] fef_set_thr,
  input logic [CNT_W-1:0] fef_clr_thr,
  input logic             line_ais,
  input logic             far_end_fail
);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable({line_ais, far_end_fail}));

  p_ais_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_ais) |-> $past(frame_stb && k2_byte[2:0] == 3'b111));

  p_fef_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(far_end_fail) |-> $past(frame_stb && k2_byte[2:0] == 3'b110));

  p_ais_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && k2_byte[2:0] == 3'b111 && line_ais) |=> line_ais);

  p_ais_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_ais) |-> $past(frame_stb && k2_byte[2:0] != 3'b111));

  p_ais_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && k2_byte[2:0] == 3'b111 && !line_ais && ais_set_thr <= 1) |=> line_ais);

  p_fef_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && k2_byte[2:0] != 3'b110 && far_end_fail && fef_clr_thr <= 1) |=> !far_end_fail);

endmodule

bind k2_line_alarm k2_line_alarm_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_k2_line_alarm.sv
module sim_k2_line_alarm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] k2_byte = 8'h00;
  logic [3:0] ais_set_thr = 4'd3, ais_clr_thr = 4'd3, fef_set_thr = 4'd3, fef_clr_thr = 4'd3;
  logic       line_ais, far_end_fail;

  int errors = 0;
  int checks = 0;
  logic       m_al [2];
  logic [3:0] m_cnt [2];

  always #10 clk = ~clk;

  k2_line_alarm u0 (.*);

  function automatic logic [4:0] model_next(input logic al, input logic [3:0] cnt,
      input logic cond, input logic [3:0] st, input logic [3:0] ct);
    logic [3:0] lim;
    logic       run;
    lim = al ? ct : st;
    if (lim == 0) lim = 1;
    run = al ? !cond : cond;
    if (!run) return {al, 4'd0};
    if (5'(cnt) + 5'd1 >= 5'(lim)) return {!al, 4'd0};
    return {al, cnt + 4'd1};
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_al[i] = 0; m_cnt[i] = 0; end
  endtask

  task automatic step(input logic stb, input logic [7:0] k2, input string tag);
    logic [4:0] r;
    frame_stb = stb;
    k2_byte = k2;
    @(posedge clk);
    if (stb) begin
      r = model_next(m_al[0], m_cnt[0], k2[2:0] == 3'b111, ais_set_thr, ais_clr_thr);
      m_al[0] = r[4]; m_cnt[0] = r[3:0];
      r = model_next(m_al[1], m_cnt[1], k2[2:0] == 3'b110, fef_set_thr, fef_clr_thr);
      m_al[1] = r[4]; m_cnt[1] = r[3:0];
    end
    @(negedge clk);
    frame_stb = 1'b0;
    check(line_ais, m_al[0], tag);
    check(far_end_fail, m_al[1], tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    check(line_ais, 1'b0, "R8 reset");
    check(far_end_fail, 1'b0, "R8 reset");
    rst_n = 1'b1;

    // R2: three AIS frames with idle gaps (R7), and bits 7..3 ignored (R1)
    step(1, 8'hF7, "R1 upper bits ignored");
    step(0, 8'h07, "R7 idle no change");
    step(1, 8'h07, "R2 second frame");
    check(line_ais, 1'b0, "R2 not yet");
    step(0, 8'h07, "R7 idle no change");
    step(1, 8'h0F, "R2 third frame");
    check(line_ais, 1'b1, "R2 asserted on third");
    // R5: condition persists
    repeat (4) step(1, 8'h07, "R5 stays set");
    // R4/R5: two clean, one AIS restarts, then three clean
    step(1, 8'h00, "R4 clean 1");
    step(1, 8'h00, "R4 clean 2");
    step(1, 8'h07, "R5 restart clear run");
    step(1, 8'h00, "R4 clean a");
    step(1, 8'h00, "R4 clean b");
    check(line_ais, 1'b1, "R5 still set");
    step(1, 8'h00, "R4 clean c");
    check(line_ais, 1'b0, "R4 cleared");
    // R3: broken run on far-end fail; R1: 111 must not count for it
    step(1, 8'h06, "R3 fef 1");
    step(1, 8'h06, "R3 fef 2");
    step(1, 8'h07, "R1 111 breaks fef run");
    step(1, 8'h06, "R3 fef 1 again");
    step(1, 8'h06, "R3 fef 2 again");
    check(far_end_fail, 1'b0, "R3 not yet");
    step(1, 8'h06, "R3 fef 3");
    check(far_end_fail, 1'b1, "R3 asserted after restart");
    // R8: reset in the middle of an alarm
    rst_n = 1'b0;
    #1;
    check(far_end_fail, 1'b0, "R8 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // R6: zero thresholds; R9 independent thresholds
    ais_set_thr = 0; ais_clr_thr = 0; fef_set_thr = 4'd15; fef_clr_thr = 4'd2;
    step(1, 8'h07, "R6 zero set acts as one");
    check(line_ais, 1'b1, "R6 asserted in one frame");
    step(1, 8'h00, "R6 zero clear acts as one");
    check(line_ais, 1'b0, "R6 cleared in one frame");
    for (int i = 0; i < 14; i++) step(1, 8'h06, "R9 fef long threshold");
    check(far_end_fail, 1'b0, "R9 not at 14");
    step(1, 8'h06, "R9 fef at 15");
    check(far_end_fail, 1'b1, "R9 set at 15");

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] k;
      if (n % 300 == 0) begin
        ais_set_thr = 4'($urandom_range(0, 6));
        ais_clr_thr = 4'($urandom_range(0, 6));
        fef_set_thr = 4'($urandom_range(0, 6));
        fef_clr_thr = 4'($urandom_range(0, 6));
      end
      k = 8'($urandom);
      case ($urandom_range(0, 3))
        0: k[2:0] = 3'b111;
        1: k[2:0] = 3'b110;
        default: ;
      endcase
      step($urandom_range(0, 3) != 0, k, "R9 random vs model");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule